// File: doc/BRIEF.md
# SEC-DED Memory Error Detection and Correction Unit

This unit protects 16-bit memory words with a 6-bit check word built from a modified Hamming code. The code corrects any single-bit error and flags any double-bit error. Each check bit is the parity of exactly eight data bits. Each data bit feeds exactly three check bits, and no two data bits share the same set of three. Two of the check bits are stored complemented, so a word that reads back as all zeros or all ones is always reported as damaged.

Two mode inputs, a strobe and a route select, step the unit through four modes:

| Strobe | Route | Mode | Outputs |
|--------|-------|------|---------|
| 0 | 0 | Generate | Check word computed from the data input |
| 0 | 1 | Read | Nothing driven; the memory word is presented |
| 1 | 1 | Flag | Error flags for the captured word |
| 1 | 0 | Correct | Repaired data word and the syndrome |

A word is captured on the rising edge of the strobe while route is high. The captured 22-bit word is held in registers clocked by the system clock. Both mode inputs are synchronized to that clock inside the block. The data and check outputs are separate ports, each with its own drive enable. The intended use is two instances: one tied to Generate on the write path, and one sequenced through Read, Flag and Correct on the read path.

Top module: `edac_sec_ded`

## Requirements
- R1: With strobe=0 and route=0 after synchronization, check_oe is 1 and data_oe is 0. check_out bit j is the XOR parity of the data bits whose column has bit j set, and bits 0 and 1 are then inverted. Data bit i < 8 takes as its column the i-th smallest 5-bit value with exactly three ones: 7, 11, 13, 14, 19, 21, 22, 25. Data bit i+8 takes the 6-bit complement of that column: 56, 52, 50, 49, 44, 42, 41, 38.
- R2: The mode inputs act after SYNC_STAGES clock edges. The data and check inputs are captured on the edge where the synchronized strobe is first seen high while the synchronized route is high. The stored word changes on no other edge, so later changes on the inputs have no effect on the flags or the corrected output.
- R3: Both flags are 0 unless the synchronized strobe is 1 and a word has been captured since the strobe was last low.
- R4: The syndrome is the stored check word XOR the check word regenerated from the stored data. When the syndrome is zero and the flags are enabled, both flags are 0.
- R5: When exactly one data bit is flipped, the syndrome equals that bit's 3-of-6 column, err_single is 1 and err_double is 0.
- R6: When exactly one check bit is flipped, the syndrome has a single one at that bit, err_single is 1, err_double is 0, and the data is passed unchanged.
- R7: Any two flipped bits, in any mix of data and check, set both err_single and err_double to 1.
- R8: A stored word of all zeros or all ones sets both flags.
- R9: With strobe=1 and route=0, data_oe and check_oe are both 1. data_out is the stored data with the located data bit inverted, and check_out is the syndrome.
- R10: In Read mode (strobe=0, route=1) neither output is enabled. Any output whose enable is 0 reads as zero.
- R11: A syndrome that has even weight, or odd weight but is neither one-hot nor a data column, is reported as a double error. This covers weight 5 and the four weight-3 patterns left unused (26, 28, 37, 35).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_strobe | input | 1 | Mode strobe; its rising edge with route high captures a word |
| ctl_route | input | 1 | Mode route select |
| data_in | input | 16 | Data word from the writer or from memory |
| check_in | input | 6 | Check word from memory |
| data_out | output | 16 | Corrected data word |
| data_oe | output | 1 | Drive enable for data_out |
| check_out | output | 6 | Generated check word or syndrome |
| check_oe | output | 1 | Drive enable for check_out |
| err_single | output | 1 | Error detected (single or double) |
| err_double | output | 1 | Uncorrectable double error detected |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 instead of the default 2, so its reference model's mode queue has to track a longer synchronizer. This shows that capture timing and flag enabling follow the parameter and are not fixed at two edges. With that latency the bench:
- flips every data bit and every check bit in turn;
- forms double errors of each kind;
- feeds the all-zero and all-one words and syndromes that land on unused weight-3 and weight-5 patterns;
- drives the inputs while a word is already held, to show they have no effect.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int DW = 16;
    localparam int CW = 6;
    localparam int SW = DW + CW;
    localparam int HALF = DW / 2;
    localparam logic [CW-1:0] INV_MASK = CW'(3);

    typedef enum logic [1:0] {
        MODE_GEN     = 2'b00,
        MODE_READ    = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_FLAG    = 2'b11
    } mode_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [CW-1:0] chk;
    } cword_t;

    typedef struct packed {
        logic          single;
        logic          dual;
        logic [DW-1:0] flip;
    } diag_t;

    // Column of data bit idx: 3-of-6 patterns built from complementary pairs.
    function automatic logic [CW-1:0] col_code(input int idx);
        int k;
        logic [CW-1:0] pat;
        logic [CW-1:0] cand;
        k   = 0;
        pat = '0;
        for (int v = 0; v < (1 << (CW - 1)); v++) begin
            cand = CW'(v);
            if ($countones(cand) == 3) begin
                if (k == (idx % HALF)) pat = cand;
                k++;
            end
        end
        return (idx < HALF) ? pat : ~pat;
    endfunction

    // Data bits that feed check bit row.
    function automatic logic [DW-1:0] row_mask(input int row);
        logic [DW-1:0] m;
        logic [CW-1:0] c;
        m = '0;
        for (int i = 0; i < DW; i++) begin
            c = col_code(i);
            m[i] = c[row];
        end
        return m;
    endfunction

endpackage

// File: rtl/edac_mode_sync.sv
module edac_mode_sync
    import edac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe_in,
    input  logic  route_in,
    output mode_e mode,
    output logic  capture
);
    logic [1:0] chain [STAGES];
    logic       strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= 2'b00;
            strobe_prev <= 1'b0;
        end else begin
            chain[0] <= {strobe_in, route_in};
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            strobe_prev <= chain[STAGES-1][1];
        end
    end

    assign mode    = mode_e'(chain[STAGES-1]);
    assign capture = chain[STAGES-1][1] & chain[STAGES-1][0] & ~strobe_prev;

endmodule

// File: rtl/edac_check_gen.sv
module edac_check_gen
    import edac_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] chk
);
    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] RMASK = row_mask(j);
        assign chk[j] = (^(data & RMASK)) ^ INV_MASK[j];
    end

endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode
    import edac_pkg::*;
(
    input  logic [CW-1:0] syn,
    output diag_t         diag
);
    logic [DW-1:0] hit;
    logic          one_hot;
    logic          nonzero;

    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [CW-1:0] COL = col_code(i);
        assign hit[i] = (syn == COL);
    end

    always_comb begin
        nonzero     = |syn;
        one_hot     = ($countones(syn) == 1);
        diag.flip   = hit;
        diag.dual   = nonzero && !one_hot && !(|hit);
        diag.single = nonzero;
    end

endmodule

// File: rtl/edac_sec_ded.sv
module edac_sec_ded
    import edac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_strobe,
    input  logic          ctl_route,
    input  logic [DW-1:0] data_in,
    input  logic [CW-1:0] check_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [CW-1:0] check_out,
    output logic          check_oe,
    output logic          err_single,
    output logic          err_double
);
    mode_e         mode_q;
    logic          latch_fire;
    cword_t        word_q;
    logic          flag_en;
    logic [CW-1:0] gen_in;
    logic [CW-1:0] gen_stored;
    logic [CW-1:0] syndrome;
    diag_t         diag;

    edac_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (ctl_strobe),
        .route_in  (ctl_route),
        .mode      (mode_q),
        .capture   (latch_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            flag_en <= 1'b0;
        end else begin
            if (latch_fire) begin
                word_q.data <= data_in;
                word_q.chk  <= check_in;
                flag_en     <= 1'b1;
            end else if (!mode_q[1]) begin
                flag_en <= 1'b0;
            end
        end
    end

    edac_check_gen u_gen_wr (.data(data_in),     .chk(gen_in));
    edac_check_gen u_gen_rd (.data(word_q.data), .chk(gen_stored));

    assign syndrome = word_q.chk ^ gen_stored;

    edac_syn_decode u_dec (.syn(syndrome), .diag(diag));

    always_comb begin
        data_out   = '0;
        data_oe    = 1'b0;
        check_out  = '0;
        check_oe   = 1'b0;
        err_single = 1'b0;
        err_double = 1'b0;
        unique case (mode_q)
            MODE_GEN: begin
                check_oe  = 1'b1;
                check_out = gen_in;
            end
            MODE_READ: begin
            end
            MODE_FLAG: begin
                err_single = flag_en & diag.single;
                err_double = flag_en & diag.dual;
            end
            MODE_CORRECT: begin
                data_oe    = 1'b1;
                check_oe   = 1'b1;
                data_out   = word_q.data ^ diag.flip;
                check_out  = syndrome;
                err_single = flag_en & diag.single;
                err_double = flag_en & diag.dual;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/edac_sec_ded_chk.sv
module edac_sec_ded_chk
    import edac_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_q,
    input logic          latch_fire,
    input logic [SW-1:0] word_q,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic [CW-1:0] check_out,
    input logic          check_oe,
    input logic          err_single,
    input logic          err_double
);
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !latch_fire |=> $stable(word_q)); // R2

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mode_q[1] |-> (!err_single && !err_double)); // R3

    AST_CLEAN_SYN: assert property (@(posedge clk) disable iff (rst)
        (data_oe && check_out == '0) |-> !err_single); // R4

    AST_DUAL_IMPLIES_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err_double |-> err_single); // R7

    AST_ONE_BIT_FIX: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ($countones(data_out ^ word_q[SW-1:CW]) <= 1)); // R9

    AST_DATA_WITH_SYN: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> check_oe); // R9

    AST_READ_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b01) |-> (!data_oe && !check_oe)); // R10

endmodule

bind edac_sec_ded edac_sec_ded_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_q     (mode_q),
    .latch_fire (latch_fire),
    .word_q     (word_q),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .check_out  (check_out),
    .check_oe   (check_oe),
    .err_single (err_single),
    .err_double (err_double)
);

// File: tb/edac_sec_ded_tb_top.sv
`timescale 1ns/1ps
module edac_sec_ded_tb_top;
    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic        route = 1'b0;
    logic [15:0] din = 16'h0;
    logic [5:0]  cin = 6'h0;
    logic [15:0] dout;
    logic        doe;
    logic [5:0]  cout;
    logic        coe;
    logic        sef;
    logic        def;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    edac_sec_ded #(.SYNC_STAGES(NS)) dut_i (
        .clk(clk), .rst(rst), .ctl_strobe(strobe), .ctl_route(route),
        .data_in(din), .check_in(cin), .data_out(dout), .data_oe(doe),
        .check_out(cout), .check_oe(coe), .err_single(sef), .err_double(def)
    );

    // Column table taken from R1
    logic [5:0] cols [16] = '{6'd7, 6'd11, 6'd13, 6'd14, 6'd19, 6'd21, 6'd22, 6'd25,
                              6'd56, 6'd52, 6'd50, 6'd49, 6'd44, 6'd42, 6'd41, 6'd38};

    function automatic logic [5:0] bgen(input logic [15:0] d);
        logic [5:0] r = 6'b000011;
        for (int i = 0; i < 16; i++) if (d[i]) r ^= cols[i];
        return r;
    endfunction

    // Returns class: 0 none, 1 data single, 2 check single, 3 dual; fix = data correction mask
    function automatic int bclass(input logic [5:0] syn, output logic [15:0] fix);
        fix = '0;
        if (syn == 0) return 0;
        for (int i = 0; i < 16; i++) if (cols[i] == syn) begin fix[i] = 1'b1; return 1; end
        if ($countones(syn) == 1) return 2;
        return 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model
    logic [1:0]  mq[$];
    logic [1:0]  m_mode = 2'b00;
    logic        m_prev = 1'b0;
    logic [15:0] m_wd = '0;
    logic [5:0]  m_wc = '0;
    logic        m_fen = 1'b0;

    initial for (int k = 0; k < NS - 1; k++) mq.push_back(2'b00);

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int k = 0; k < NS - 1; k++) mq.push_back(2'b00);
            m_mode = 2'b00; m_prev = 1'b0; m_wd = '0; m_wc = '0; m_fen = 1'b0;
        end else begin
            if (m_mode == 2'b11 && !m_prev) begin
                m_wd = din; m_wc = cin; m_fen = 1'b1;
            end else if (!m_mode[1]) m_fen = 1'b0;
            m_prev = m_mode[1];
            mq.push_back({strobe, route});
            m_mode = mq.pop_front();
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] fix;
            logic [5:0]  syn;
            int          cl;
            logic        e_doe, e_coe, e_sef, e_def;
            logic [15:0] e_dout;
            logic [5:0]  e_cout;
            string       ftag;
            syn = m_wc ^ bgen(m_wd);
            cl  = bclass(syn, fix);
            e_doe = 0; e_coe = 0; e_dout = 0; e_cout = 0;
            if (m_mode == 2'b00) begin e_coe = 1; e_cout = bgen(din); end
            if (m_mode == 2'b10) begin e_doe = 1; e_coe = 1; e_dout = m_wd ^ fix; e_cout = syn; end
            e_sef = m_fen && m_mode[1] && cl != 0;
            e_def = m_fen && m_mode[1] && cl == 3;
            if (!(m_fen && m_mode[1])) ftag = "R3";
            else if (cl == 0) ftag = "R4";
            else if (cl == 1) ftag = "R5";
            else if (cl == 2) ftag = "R6";
            else ftag = "R7";
            chk(coe == e_coe && cout == e_cout, m_mode == 2'b00 ? "R1 clk check" : "R9 clk check",
                {25'd0, coe, cout}, {25'd0, e_coe, e_cout});
            chk(doe == e_doe && dout == e_dout, "R10 clk data",
                {15'd0, doe, dout}, {15'd0, e_doe, e_dout});
            chk(sef == e_sef && def == e_def, {ftag, " clk flags"},
                {30'd0, sef, def}, {30'd0, e_sef, e_def});
        end
    end

    task automatic drive(input logic s, input logic r, input logic [15:0] d, input logic [5:0] c);
        @(posedge clk); #1;
        strobe = s; route = r; din = d; cin = c;
    endtask

    task automatic settle();
        repeat (NS + 2) @(posedge clk);
        @(negedge clk); #0.5;
    endtask

    // Read a word, check flags in Flag mode and the output in Correct mode
    task automatic read_case(input logic [15:0] d, input logic [5:0] c, input logic e_sef,
                             input logic e_def, input logic [15:0] e_dout, input logic [5:0] e_syn,
                             input string tag);
        drive(0, 1, d, c); settle();
        drive(1, 1, d, c); settle();
        chk(sef == e_sef && def == e_def, {tag, " flags"}, {30'd0, sef, def}, {30'd0, e_sef, e_def});
        drive(1, 0, 16'h0, 6'h0); settle();
        chk(dout == e_dout && doe, {tag, " data_out"}, {15'd0, doe, dout}, {15'd1, e_dout});
        chk(cout == e_syn, {tag, " syndrome"}, {26'd0, cout}, {26'd0, e_syn});
        drive(0, 1, 16'h0, 6'h0); settle();
        chk(!sef && !def, "R3 flags drop", {30'd0, sef, def}, 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(coe && !doe && !sef && !def && cout == 6'b000011, "R1 reset state",
            {24'd0, coe, doe, sef, def, 2'd0, cout[1:0]}, {24'd0, 4'b1000, 2'd0, 2'b11});

        // R1 generation
        drive(0, 0, 16'h0001, 6'h0); settle();
        chk(cout == 6'b000100, "R1 gen bit0", {26'd0, cout}, 32'h04);
        drive(0, 0, 16'hFFFF, 6'h0); settle();
        chk(cout == 6'b000011, "R1 gen ones", {26'd0, cout}, 32'h03);
        drive(0, 0, 16'hA5C3, 6'h0); settle();
        chk(cout == bgen(16'hA5C3), "R1 gen mix", {26'd0, cout}, {26'd0, bgen(16'hA5C3)});
        drive(0, 1, 16'hA5C3, 6'h0); settle();
        chk(!coe && !doe && cout == 0 && dout == 0, "R10 read silent",
            {8'd0, coe, doe, cout, dout}, 32'd0);

        // R4 clean
        read_case(16'h3C5A, bgen(16'h3C5A), 0, 0, 16'h3C5A, 6'h0, "R4 clean");

        // R5 and R9 each data bit
        for (int i = 0; i < 16; i++) begin
            d = 16'h6B1D;
            read_case(d ^ (16'h1 << i), bgen(d), 1, 0, d, cols[i], "R5 R9 data bit");
        end
        // R6 each check bit
        for (int j = 0; j < 6; j++) begin
            d = 16'h92E4;
            read_case(d, bgen(d) ^ (6'h1 << j), 1, 0, d, 6'h1 << j, "R6 check bit");
        end
        // R7 doubles
        d = 16'h1357;
        read_case(d ^ 16'h0081, bgen(d), 1, 1, d ^ 16'h0081, cols[0] ^ cols[7], "R7 two data");
        read_case(d ^ 16'h0400, bgen(d) ^ 6'h20, 1, 1, d ^ 16'h0400, cols[10] ^ 6'h20, "R7 data+check");
        read_case(d, bgen(d) ^ 6'h09, 1, 1, d, 6'h09, "R7 two check");
        // R8 gross words
        read_case(16'h0000, 6'h00, 1, 1, 16'h0000, 6'b000011, "R8 all zero");
        read_case(16'hFFFF, 6'h3F, 1, 1, 16'hFFFF, 6'b111100, "R8 all one");
        // R11 unused weight-3 and weight-5
        d = 16'h0F0F;
        read_case(d, bgen(d) ^ 6'd26, 1, 1, d, 6'd26, "R11 unused col");
        read_case(d, bgen(d) ^ 6'd35, 1, 1, d, 6'd35, "R11 unused col2");
        read_case(d, bgen(d) ^ 6'h1F, 1, 1, d, 6'h1F, "R11 weight5");

        // R2 inputs ignored after capture
        d = 16'hBEEF;
        drive(0, 1, d ^ 16'h0010, bgen(d)); settle();
        drive(1, 1, d ^ 16'h0010, bgen(d)); settle();
        drive(1, 1, 16'h0000, 6'h00); settle();
        chk(sef && !def, "R2 held flags", {30'd0, sef, def}, 32'h2);
        drive(1, 0, 16'hFFFF, 6'h3F); settle();
        chk(dout == d && cout == cols[4], "R2 held word", {10'd0, cout, dout}, {10'd0, cols[4], d});
        drive(0, 1, 16'h0, 6'h0); settle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule